// File: doc/BRIEF.md
# Sector Protect Pulse Sequencer

This block is a host-side controller that runs the protect algorithm for a single sector of a parallel NOR flash. Software or a higher-level engine gives it a start strobe and a sector number. The block then produces the bus cycles the flash needs. It writes the protect command to a specially encoded address inside the sector and leaves the bus quiet for a programmable pulse time. It then writes the verify command and reads the protection status back.

A status of 01h means the sector is now protected, and the sequencer finishes with a pass verdict. Any other status counts as a failed attempt: the attempt counter steps up and the whole pulse is applied again. When the attempt at the counter limit also fails, the sequencer stops with a fail verdict. Every bus cycle is a request held until the bus side acknowledges it, so the block works with bus masters of any latency.

Top module: `sector_protect_seq`

## Requirements
- R1: After synchronous reset the block is idle: `busy`, `done`, `pass`, `fail` and `bus_req` are low, and `pulse_count` is 0.
- R2: On an accepted `start`, the first bus cycle is a write of data 60h. Its address carries the sector number in the top `SECT_W` bits and sets bit 1. Bit 0, bit 6 and every other lower bit are 0. `pulse_count` reads 1 during this first attempt.
- R3: A raised `bus_req` stays high, with `bus_addr`, `bus_we` and `bus_wdata` unchanged, until the cycle in which `bus_ack` is high. A cycle completes in that same acknowledged clock.
- R4: After the protect write is acknowledged, `bus_req` stays low for exactly `WAIT_CYCLES` = `CLK_FREQ_KHZ`*`PULSE_US`/1000 clocks. In the next clock the verify write is requested.
- R5: The verify step is a write of 40h to the same address as the protect write. After it is acknowledged, a read (`bus_we` low) of that address is requested in the next clock.
- R6: If the acknowledged read returns exactly 01h, the block leaves busy and raises `done` and `pass`.
- R7: If the acknowledged read returns any other value and `pulse_count` is below `MAX_PULSES`, `pulse_count` increments and the protect write is requested again in the next clock.
- R8: If the read fails while `pulse_count` equals `MAX_PULSES`, the block raises `done` and `fail`. `pulse_count` never exceeds `MAX_PULSES`.
- R9: `done` and the verdict stay high until the next accepted `start`. `pass` and `fail` are never high together. A `start` while busy is ignored, including its sector number.
- R10: `busy` is high from the clock after an accepted `start` until the final read is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, taken when not busy |
| sector | input | SECT_W | Sector number, captured with start |
| busy | output | 1 | Algorithm in progress |
| done | output | 1 | Algorithm finished, held |
| pass | output | 1 | Sector verified protected |
| fail | output | 1 | Attempt limit exhausted |
| pulse_count | output | $clog2(MAX_PULSES+1) | Current attempt number |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Bus cycle completes this clock |
| bus_rdata | input | 8 | Read data, valid with bus_ack on a read |

## Verification
The bench varies acknowledge latency from zero to several clocks. A design that dropped or changed the request before the acknowledge, or counted wait clocks from the request rather than from its completion, would then show up as a request or address mismatch. Readbacks include near-miss values such as 81h and 00h. A design that tested a single bit would pass too early on them. A run in which every readback fails takes the counter to its limit, which exposes an off-by-one in the limit as one pulse too many or too few. A start fired mid-run with a different sector would change the bus address in a design that did not ignore it.

// File: rtl/spp_pkg.sv
package spp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROT,
        ST_WAIT,
        ST_VWR,
        ST_VRD,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        VERDICT_NONE,
        VERDICT_PASS,
        VERDICT_FAIL
    } verdict_e;

    typedef struct packed {
        logic       req;
        logic       we;
        logic [7:0] wdata;
    } bus_op_t;

    localparam logic [7:0] CMD_PROTECT      = 8'h60;
    localparam logic [7:0] CMD_VERIFY       = 8'h40;
    localparam logic [7:0] STATUS_PROTECTED = 8'h01;

    // Clock count for a pulse of the given length, at least one clock.
    function automatic int pulse_wait_cycles(input int freq_khz, input int pulse_us);
        int n;
        n = (freq_khz * pulse_us) / 1000;
        return (n < 1) ? 1 : n;
    endfunction

endpackage

// File: rtl/spp_pulse_timer.sv
module spp_pulse_timer #(
    parameter int CYCLES = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(CYCLES + 1);
    localparam logic [TW-1:0] RELOAD = TW'(CYCLES - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run && (cnt_q == '0);

    AST_EXPIRE_ONCE: assert property (@(posedge clk) disable iff (rst)
        expired |=> !expired); // R4

endmodule

// File: rtl/spp_attempt_ctr.sv
module spp_attempt_ctr #(
    parameter int MAX_PULSES = 25,
    parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PULSES);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (restart) begin
            count_q <= CNT_W'(1);
        end else if (step && count_q != LIMIT) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count    = count_q;
    assign at_limit = (count_q == LIMIT);

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        count_q <= LIMIT); // R8
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (count_q != $past(count_q)) |-> (count_q == CNT_W'(1) || count_q == $past(count_q) + 1'b1)); // R7

endmodule

// File: rtl/sector_protect_seq.sv
module sector_protect_seq
    import spp_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int SECT_W       = 4,
    parameter int CLK_FREQ_KHZ = 100,
    parameter int PULSE_US     = 150,
    parameter int MAX_PULSES   = 25,
    parameter int CNT_W        = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SECT_W-1:0] sector,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [CNT_W-1:0]  pulse_count,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata
);
    localparam int WAIT_CYCLES = pulse_wait_cycles(CLK_FREQ_KHZ, PULSE_US);
    localparam int LOW_W       = ADDR_W - SECT_W;
    // Low address field of the protect and verify cycles: bit 1 set, bits 0 and 6 clear.
    localparam logic [LOW_W-1:0] CYCLE_LOW = LOW_W'(2);

    seq_state_e        state_q, state_d;
    verdict_e          verdict_q, verdict_d;
    logic [SECT_W-1:0] sect_q;
    bus_op_t           op;
    logic              accept;
    logic              timer_load, timer_run, timer_expired;
    logic              ctr_step, ctr_at_limit;
    logic              read_done, read_ok;

    assign accept    = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign read_done = (state_q == ST_VRD) && bus_ack;
    assign read_ok   = (bus_rdata == STATUS_PROTECTED);

    assign timer_load = (state_q == ST_PROT) && bus_ack;
    assign timer_run  = (state_q == ST_WAIT);
    assign ctr_step   = read_done && !read_ok && !ctr_at_limit;

    spp_pulse_timer #(
        .CYCLES (WAIT_CYCLES)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .run     (timer_run),
        .expired (timer_expired)
    );

    spp_attempt_ctr #(
        .MAX_PULSES (MAX_PULSES),
        .CNT_W      (CNT_W)
    ) i_attempts (
        .clk      (clk),
        .rst      (rst),
        .restart  (accept),
        .step     (ctr_step),
        .count    (pulse_count),
        .at_limit (ctr_at_limit)
    );

    always_comb begin
        state_d   = state_q;
        verdict_d = verdict_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    state_d   = ST_PROT;
                    verdict_d = VERDICT_NONE;
                end
            end
            ST_PROT: if (bus_ack)       state_d = ST_WAIT;
            ST_WAIT: if (timer_expired) state_d = ST_VWR;
            ST_VWR:  if (bus_ack)       state_d = ST_VRD;
            ST_VRD: begin
                if (bus_ack) begin
                    if (read_ok) begin
                        state_d   = ST_DONE;
                        verdict_d = VERDICT_PASS;
                    end else if (ctr_at_limit) begin
                        state_d   = ST_DONE;
                        verdict_d = VERDICT_FAIL;
                    end else begin
                        state_d   = ST_PROT;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            verdict_q <= VERDICT_NONE;
            sect_q    <= '0;
        end else begin
            state_q   <= state_d;
            verdict_q <= verdict_d;
            if (accept) sect_q <= sector;
        end
    end

    always_comb begin
        op = '0;
        unique case (state_q)
            ST_PROT: op = '{req: 1'b1, we: 1'b1, wdata: CMD_PROTECT};
            ST_VWR:  op = '{req: 1'b1, we: 1'b1, wdata: CMD_VERIFY};
            ST_VRD:  op = '{req: 1'b1, we: 1'b0, wdata: 8'h00};
            default: op = '0;
        endcase
    end

    assign bus_req   = op.req;
    assign bus_we    = op.we;
    assign bus_wdata = op.wdata;
    assign bus_addr  = {sect_q, CYCLE_LOW};

    assign busy = (state_q == ST_PROT) || (state_q == ST_WAIT) ||
                  (state_q == ST_VWR)  || (state_q == ST_VRD);
    assign done = (state_q == ST_DONE);
    assign pass = (verdict_q == VERDICT_PASS);
    assign fail = (verdict_q == VERDICT_FAIL);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R3
    AST_PROT_ENCODING: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_wdata == CMD_PROTECT) |-> (bus_addr[6] == 1'b0 && bus_addr[1:0] == 2'b10)); // R2
    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail)); // R9
    AST_DONE_HAS_VERDICT: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass || fail)); // R6
    AST_BUSY_SECTOR_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sect_q)); // R9
    AST_VERIFY_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
        timer_expired |=> (bus_req && bus_we && bus_wdata == CMD_VERIFY)); // R4

endmodule

// File: tb/test_sector_protect_seq.sv
module test_sector_protect_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int SECT_W     = 4;
    localparam int FREQ_KHZ   = 100;
    localparam int PULSE_US   = 150;
    localparam int MAXP       = 25;
    localparam int CNT_W      = $clog2(MAXP + 1);
    localparam int WAITC      = FREQ_KHZ * PULSE_US / 1000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [SECT_W-1:0] sector = '0;
    logic              busy, done, pass, fail;
    logic [CNT_W-1:0]  pulse_count;
    logic              bus_req, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic              bus_ack = 1'b0;
    logic [7:0]        bus_rdata = 8'h00;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    // Bus responder settings
    int         lat = 0;
    int         req_age = 0;
    logic [7:0] rb_q[$];

    // Reference model: 0 idle, 1 protect write, 2 wait, 3 verify write, 4 read, 5 done
    int m_phase = 0;
    int m_wait  = 0;
    int m_pulse = 0;
    int m_sect  = 0;
    bit m_pass  = 0;
    bit m_fail  = 0;

    sector_protect_seq #(
        .ADDR_W       (ADDR_W),
        .SECT_W       (SECT_W),
        .CLK_FREQ_KHZ (FREQ_KHZ),
        .PULSE_US     (PULSE_US),
        .MAX_PULSES   (MAXP)
    ) i_sector_protect_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sector      (sector),
        .busy        (busy),
        .done        (done),
        .pass        (pass),
        .fail        (fail),
        .pulse_count (pulse_count),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_ack     (bus_ack),
        .bus_rdata   (bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic longint exp_addr(input int s);
        return (longint'(s) << (ADDR_W - SECT_W)) | 64'd2;
    endfunction

    // Model update at the clock edge, from the inputs driven at the last falling edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_phase = 0; m_pulse = 0; m_pass = 0; m_fail = 0; m_sect = 0;
        end else begin
            case (m_phase)
                0, 5: if (start) begin
                    m_phase = 1; m_pulse = 1; m_sect = int'(sector);
                    m_pass = 0; m_fail = 0;
                end
                1: if (bus_ack) begin m_phase = 2; m_wait = WAITC; end
                2: begin
                    m_wait--;
                    if (m_wait == 0) m_phase = 3;
                end
                3: if (bus_ack) m_phase = 4;
                4: if (bus_ack) begin
                    if (bus_rdata == 8'h01) begin m_phase = 5; m_pass = 1; end
                    else if (m_pulse == MAXP) begin m_phase = 5; m_fail = 1; end
                    else begin m_pulse++; m_phase = 1; end
                end
                default: m_phase = 0;
            endcase
        end
    end

    // Compare every clock, then drive the responder for the next edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit ereq;
            ereq = (m_phase >= 1 && m_phase <= 4 && m_phase != 2);
            chk(busy == (m_phase >= 1 && m_phase <= 4), "R10", "busy", busy, m_phase >= 1 && m_phase <= 4);
            chk(done == (m_phase == 5), "R6", "done", done, m_phase == 5);
            chk(pass == m_pass, "R6", "pass", pass, m_pass);
            chk(fail == m_fail, "R8", "fail", fail, m_fail);
            chk(int'(pulse_count) == m_pulse, "R7", "pulse_count", pulse_count, m_pulse);
            chk(bus_req == ereq, "R4", "bus_req", bus_req, ereq);
            if (ereq && bus_req) begin
                chk(longint'(bus_addr) == exp_addr(m_sect), "R2", "bus_addr", bus_addr, exp_addr(m_sect));
                chk(bus_we == (m_phase != 4), "R5", "bus_we", bus_we, m_phase != 4);
                if (m_phase == 1) chk(bus_wdata == 8'h60, "R2", "protect data", bus_wdata, 8'h60);
                if (m_phase == 3) chk(bus_wdata == 8'h40, "R5", "verify data", bus_wdata, 8'h40);
            end
        end
        if (bus_req && !rst) begin
            if (req_age >= lat) begin
                bus_ack = 1'b1;
                bus_rdata = (!bus_we && rb_q.size() > 0) ? rb_q.pop_front() : 8'h00;
                req_age = 0;
            end else begin
                bus_ack = 1'b0;
                req_age++;
            end
        end else begin
            bus_ack = 1'b0;
            req_age = 0;
        end
    end

    task automatic fire_start(input int s);
        @(negedge clk);
        start  = 1'b1;
        sector = SECT_W'(s);
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && m_phase != 5; i++) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !pass && !fail && !bus_req, "R1", "flags in reset", {busy, done, pass, fail, bus_req}, 0);
        chk(pulse_count == '0, "R1", "pulse_count in reset", pulse_count, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2 R6: first attempt passes, zero latency
        lat = 0; rb_q = '{8'h01};
        fire_start(5);
        wait_done();
        chk(pass && !fail && done, "R6", "pass after one pulse", {pass, fail}, 2'b10);
        chk(pulse_count == CNT_W'(1), "R2", "pulses used", pulse_count, 1);
        repeat (4) @(negedge clk);
        chk(done && pass, "R9", "verdict held", {done, pass}, 2'b11);

        // R7: near-miss readbacks, latency 2; start mid-run ignored (R9)
        lat = 2; rb_q = '{8'h00, 8'h81, 8'h01};
        fire_start(10);
        repeat (20) @(negedge clk);
        fire_start(3);
        wait_done();
        chk(pass && pulse_count == CNT_W'(3), "R7", "pass on third pulse", pulse_count, 3);

        // R8: every readback fails, latency 1
        lat = 1; rb_q = {};
        fire_start(15);
        wait_done();
        chk(fail && !pass && done, "R8", "fail at limit", {pass, fail}, 2'b01);
        chk(pulse_count == CNT_W'(MAXP), "R8", "pulses at limit", pulse_count, MAXP);

        // R9: restart after fail clears verdict
        lat = 0; rb_q = '{8'h01};
        fire_start(0);
        chk(!fail && !pass && busy, "R9", "verdict cleared on start", {pass, fail}, 0);
        wait_done();
        chk(pass, "R6", "pass after restart", pass, 1);
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule